// File: doc/BRIEF.md
# Ceiling-Gated Nested Interrupt Dispatcher

This block decides which interrupt line a single-core processor should service next. Each line has three properties: a sticky pending flag, an enable bit and a static priority. The block keeps a stack of running priorities. A higher-priority line can therefore preempt the handler that is running, and when it returns the preempted handler resumes at its own priority.

A second stack holds the system ceiling. Software raises the ceiling with a lock strobe that carries a resource ceiling value, and restores it with an unlock strobe. Locks unwind strictly last-in, first-out. A line is started only when its priority is strictly above both the running priority and the ceiling. This gives stack-based resource protection without further scheduling logic.

Every dispatch decision is registered. The dispatch strobe, the vector index and the new running priority all appear on the clock after the event that made a line eligible: a pend, a return or an unlock.

Top module: `ngd_dispatch`

## Requirements
- R1: After reset the running priority and the system ceiling are 0, the dispatch strobe and error flag are low, and the vector output is 0.
- R2: Only the highest-priority line among those both pending and enabled is considered. Among lines of equal priority the lowest index wins. A pending line that is disabled is not dispatched, but it stays pending until enabled.
- R3: A candidate is dispatched only when its priority is strictly greater than the running priority and strictly greater than the system ceiling. A line of equal priority never preempts, and a line whose priority equals the ceiling stays blocked.
- R4: On dispatch the running priority becomes the dispatched line's priority. A return strobe restores the priority of the preempted handler, or 0 when no handler remains.
- R5: A lock sets the system ceiling to the value carried with it and saves the previous ceiling. An unlock restores the most recently saved value, so nested locks unwind in last-in, first-out order.
- R6: The dispatch strobe rises on the clock edge that samples the enabling pend, return or unlock. It is high for exactly one cycle, and the vector output then holds the index of the dispatched line.
- R7: A line's pending flag clears when the line is dispatched, so the line is not started again until it is pended anew.
- R8: The error flag pulses for one cycle after an illegal request, and the request is ignored. The illegal requests are: a lock with the ceiling stack full (DEPTH entries), an unlock with no lock outstanding, a return with no handler running, and a lock and an unlock in the same cycle.
- R9: A line configured with priority 0 is never dispatched.
- R10: A return and a dispatch in the same cycle are both applied. The candidate is compared against the priority restored by the return, and its priority replaces the returning handler's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_LINES | Per-line pend request pulses |
| enable_i | input | NUM_LINES | Per-line enable bits |
| prio_i | input | NUM_LINES*PRIO_W | Static priority of each line, line i at bits [i*PRIO_W +: PRIO_W] |
| ret_i | input | 1 | Handler return strobe |
| lock_i | input | 1 | Lock strobe (raise ceiling) |
| unlock_i | input | 1 | Unlock strobe (restore ceiling) |
| lock_ceil_i | input | PRIO_W | Resource ceiling carried by a lock |
| vec_o | output | $clog2(NUM_LINES) | Index of the most recently dispatched line |
| dispatch_o | output | 1 | One-cycle dispatch strobe |
| run_prio_o | output | PRIO_W | Current running priority |
| ceiling_o | output | PRIO_W | Current system ceiling |
| err_o | output | 1 | One-cycle error pulse for an ignored request |

## Verification
The bench targets these corner cases:
- A line whose priority equals the ceiling. A design that compares with greater-or-equal would start it while the lock is still held.
- Two lines of equal priority pended together. A wrong tie-break would start the higher index first, or let the second preempt the first.
- A return that coincides with a pending candidate. A design that skips the restored priority would either stall for a cycle or lose the returning entry.
- Stack boundaries: a ninth lock, and unlocks and returns on empty stacks. A design without guards would wrap its depth counter and report garbage ceilings and priorities.

// File: rtl/ngd_pkg.sv
package ngd_pkg;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/ngd_arb.sv
module ngd_arb #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 4,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        req_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           prio_o
);

    logic [PRIO_W-1:0] line_prio [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
        assign line_prio[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Strictly-greater scan: lowest index keeps a tie, priority 0 never wins
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req_i[i] && (line_prio[i] > prio_o)) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = line_prio[i];
            end
        end
    end

endmodule

// File: rtl/ngd_lifo.sv
module ngd_lifo #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] below_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);
    import ngd_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } lifo_st_t;

    lifo_st_t st_d, st_q;
    logic     pop_ok, push_ok;
    stk_op_e  op;

    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign top_o   = empty_o ? '0 : st_q.mem[st_q.cnt - 1'b1];
    assign below_o = (st_q.cnt < CNT_W'(2)) ? '0 : st_q.mem[st_q.cnt - CNT_W'(2)];

    always_comb begin
        pop_ok  = pop_i && !empty_o;
        push_ok = push_i && (!full_o || pop_ok);
        err_o   = (pop_i && !pop_ok) || (push_i && !push_ok);
        if (pop_ok && push_ok)  op = STK_SWAP;
        else if (push_ok)       op = STK_PUSH;
        else if (pop_ok)        op = STK_POP;
        else                    op = STK_HOLD;

        st_d = st_q;
        case (op)
            STK_SWAP: st_d.mem[st_q.cnt - 1'b1] = data_i;
            STK_PUSH: begin
                st_d.mem[st_q.cnt] = data_i;
                st_d.cnt           = st_q.cnt + 1'b1;
            end
            STK_POP:  st_d.cnt = st_q.cnt - 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R8
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);

    // R5
    pop_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i) |=> (top_o == $past(below_o)));

endmodule

// File: rtl/ngd_dispatch.sv
module ngd_dispatch #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 4,
    parameter int unsigned DEPTH     = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        pend_i,
    input  logic [NUM_LINES-1:0]        enable_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    input  logic                        ret_i,
    input  logic                        lock_i,
    input  logic                        unlock_i,
    input  logic [PRIO_W-1:0]           lock_ceil_i,
    output logic [IDX_W-1:0]            vec_o,
    output logic                        dispatch_o,
    output logic [PRIO_W-1:0]           run_prio_o,
    output logic [PRIO_W-1:0]           ceiling_o,
    output logic                        err_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic                 disp;
        logic [IDX_W-1:0]     vec;
        logic                 err;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic [NUM_LINES-1:0] pend_all, req;
    logic                 hit;
    logic [IDX_W-1:0]     win_idx;
    logic [PRIO_W-1:0]    win_prio;

    logic [PRIO_W-1:0] run_top, run_below, ceil_top, ceil_below;
    logic              run_full, run_empty, run_err;
    logic              ceil_full, ceil_empty, ceil_err;

    logic              ret_ok, lock_req, unlock_req, lock_ok, unlock_ok, go;
    logic [PRIO_W-1:0] run_eff, ceil_eff;

    assign pend_all = st_q.pend | pend_i;
    assign req      = pend_all & enable_i;

    ngd_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
        .req_i  (req),
        .prio_i (prio_i),
        .hit_o  (hit),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    ngd_lifo #(.WIDTH(PRIO_W), .DEPTH(DEPTH)) u_run_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (go),
        .pop_i   (ret_i),
        .data_i  (win_prio),
        .top_o   (run_top),
        .below_o (run_below),
        .full_o  (run_full),
        .empty_o (run_empty),
        .err_o   (run_err)
    );

    ngd_lifo #(.WIDTH(PRIO_W), .DEPTH(DEPTH)) u_ceil_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (lock_req),
        .pop_i   (unlock_req),
        .data_i  (lock_ceil_i),
        .top_o   (ceil_top),
        .below_o (ceil_below),
        .full_o  (ceil_full),
        .empty_o (ceil_empty),
        .err_o   (ceil_err)
    );

    always_comb begin
        ret_ok     = ret_i && !run_empty;
        run_eff    = ret_ok ? run_below : run_top;
        lock_req   = lock_i && !unlock_i;
        unlock_req = unlock_i && !lock_i;
        lock_ok    = lock_req && !ceil_full;
        unlock_ok  = unlock_req && !ceil_empty;
        if (lock_ok)        ceil_eff = lock_ceil_i;
        else if (unlock_ok) ceil_eff = ceil_below;
        else                ceil_eff = ceil_top;

        go = hit && (win_prio > run_eff) && (win_prio > ceil_eff)
                 && (!run_full || ret_ok);

        st_d      = st_q;
        st_d.pend = pend_all;
        st_d.disp = go;
        st_d.err  = run_err || ceil_err || (lock_i && unlock_i);
        if (go) begin
            st_d.vec           = win_idx;
            st_d.pend[win_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_o      = st_q.vec;
    assign dispatch_o = st_q.disp;
    assign err_o      = st_q.err;
    assign run_prio_o = run_top;
    assign ceiling_o  = ceil_top;

    // R3
    above_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> (run_prio_o > ceiling_o));

    // R7
    pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> !st_q.pend[vec_o]);

    // R4
    run_prio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> (run_prio_o == prio_i[vec_o*PRIO_W +: PRIO_W]));

    // R9
    no_zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> (run_prio_o != '0));

    // R8
    clash_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && unlock_i) |=> (ceiling_o == $past(ceiling_o)));

endmodule

// File: tb/tb_ngd_dispatch.sv
module tb_ngd_dispatch;
    localparam int N     = 8;
    localparam int PW    = 4;
    localparam int DEPTH = 8;
    // line7..line0 priorities: 1,7,0,4,2,5,5,3
    localparam logic [N*PW-1:0] PRIO_CFG =
        {4'd1, 4'd7, 4'd0, 4'd4, 4'd2, 4'd5, 4'd5, 4'd3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  enable_i = '1;
    logic          ret_i = 1'b0, lock_i = 1'b0, unlock_i = 1'b0;
    logic [PW-1:0] lock_ceil_i = '0;
    logic [2:0]    vec_o;
    logic          dispatch_o, err_o;
    logic [PW-1:0] run_prio_o, ceiling_o;

    ngd_dispatch #(.NUM_LINES(N), .PRIO_W(PW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .enable_i(enable_i),
        .prio_i(PRIO_CFG), .ret_i(ret_i), .lock_i(lock_i), .unlock_i(unlock_i),
        .lock_ceil_i(lock_ceil_i), .vec_o(vec_o), .dispatch_o(dispatch_o),
        .run_prio_o(run_prio_o), .ceiling_o(ceiling_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int     run_q[$];
    int     ceil_q[$];
    bit [N-1:0] m_pend = '0;
    int     e_vec = 0;
    bit     e_disp = 0, e_err = 0;

    function automatic int lprio(int i);
        return int'(PRIO_CFG[i*PW +: PW]);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int rp, cl, best, bp;
        e_err  = 0;
        e_disp = 0;
        if (ret_i) begin
            if (run_q.size() == 0) e_err = 1; else void'(run_q.pop_back());
        end
        if (lock_i && unlock_i) e_err = 1;
        else if (lock_i) begin
            if (ceil_q.size() == DEPTH) e_err = 1; else ceil_q.push_back(int'(lock_ceil_i));
        end else if (unlock_i) begin
            if (ceil_q.size() == 0) e_err = 1; else void'(ceil_q.pop_back());
        end
        m_pend |= pend_i;
        rp = (run_q.size() != 0) ? run_q[$] : 0;
        cl = (ceil_q.size() != 0) ? ceil_q[$] : 0;
        best = -1; bp = 0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && enable_i[i] && lprio(i) > bp) begin best = i; bp = lprio(i); end
        if (best >= 0 && bp > rp && bp > cl && run_q.size() < DEPTH) begin
            e_disp = 1;
            e_vec  = best;
            m_pend[best] = 1'b0;
            run_q.push_back(bp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "dispatch", int'(dispatch_o), int'(e_disp));
        chk(tag, "vec", int'(vec_o), e_vec);
        chk(tag, "run_prio", int'(run_prio_o), (run_q.size() != 0) ? run_q[$] : 0);
        chk(tag, "ceiling", int'(ceiling_o), (ceil_q.size() != 0) ? ceil_q[$] : 0);
        chk(tag, "err", int'(err_o), int'(e_err));
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        pend_i = '0; ret_i = 0; lock_i = 0; unlock_i = 0;
    endtask

    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        idle("R1", 2);

        // R6/R2: single pend starts one cycle later
        pend_i[3] = 1; cyc("R6");
        // R2 tie + R4 preemption: lines 1 and 2 both priority 5
        pend_i[1] = 1; pend_i[2] = 1; cyc("R2");
        idle("R3", 2);               // equal priority line 2 must not preempt
        ret_i = 1; cyc("R10");       // return and dispatch of line 2 together
        ret_i = 1; cyc("R4");        // back to priority 2
        ret_i = 1; cyc("R4");        // back to idle
        idle("R7", 3);               // no re-dispatch of cleared lines

        // R3/R6: ceiling equal to line priority blocks, unlock releases
        lock_i = 1; lock_ceil_i = 4; cyc("R5");
        pend_i[4] = 1; cyc("R3");
        idle("R3", 3);
        unlock_i = 1; cyc("R6");
        ret_i = 1; cyc("R4");

        // R5 nested locks unwind LIFO
        lock_i = 1; lock_ceil_i = 3; cyc("R5");
        lock_i = 1; lock_ceil_i = 6; cyc("R5");
        pend_i[6] = 1; cyc("R3");    // priority 7 beats ceiling 6
        ret_i = 1; cyc("R4");
        unlock_i = 1; cyc("R5");
        unlock_i = 1; cyc("R5");

        // R2 disabled line stays pending
        enable_i[0] = 0; pend_i[0] = 1; cyc("R2");
        idle("R2", 2);
        enable_i[0] = 1; cyc("R2");
        ret_i = 1; cyc("R4");

        // R9 priority-0 line never starts
        pend_i[5] = 1; cyc("R9");
        idle("R9", 3);

        // R8 illegal requests
        ret_i = 1; cyc("R8");
        unlock_i = 1; cyc("R8");
        lock_i = 1; unlock_i = 1; lock_ceil_i = 9; cyc("R8");
        for (int k = 0; k < DEPTH + 1; k++) begin
            lock_i = 1; lock_ceil_i = PW'(k + 1); cyc("R8");
        end
        for (int k = 0; k < DEPTH; k++) begin
            unlock_i = 1; cyc("R5");
        end
        idle("R8", 2);

        // mixed random traffic against the reference model
        for (int k = 0; k < 3000; k++) begin
            pend_i = (($urandom % 4) == 0) ? N'($urandom) : '0;
            ret_i = (($urandom % 5) == 0);
            lock_i = (($urandom % 8) == 0);
            unlock_i = (($urandom % 8) == 0);
            lock_ceil_i = PW'($urandom);
            enable_i = (($urandom % 16) == 0) ? N'($urandom) : enable_i | N'($urandom);
            cyc("R6");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule